// File: doc/BRIEF.md
# CD frame sync lock detector

This block follows the detected sync-pattern events that a CD channel decoder produces and decides whether frame timing is locked. Time is counted in channel-bit periods (T). Each period is marked by a one-cycle enable from outside. A frame is 588 T long. Each detected sync is measured against the position where the next frame should start. A sync that falls inside a selectable tolerance window realigns the timing. A sync outside that window is ignored.

When no acceptable sync arrives while the block is locked, it supplies the frame start itself, so frame timing continues for a programmable number of frames. After the last of those frames it drops lock. The frame-start strobe covers real starts and inserted starts, and a separate level shows that the current frame was inserted. The play-speed field does not change how the block counts. It is decoded into a one-hot rate request for the logic that generates the channel-bit enable.

Top module: `cd_sync_lock`

## Requirements
- R1: While rst_ni is low, and after it rises until the first event, lock_o, frame_o and ins_o are 0.
- R2: While unlocked, every sync_i seen with bit_en_i high is accepted as a frame start. frame_o pulses for one clock in the cycle after that enabled cycle, and ins_o goes to 0.
- R3: While unlocked, lock_o rises together with the frame_o of an accepted sync that lies 588 T ± window after the previous accepted sync. A sync at any other spacing leaves lock_o at 0 and becomes the new reference.
- R4: The window is ±10 T (offsets 578 to 598 from the last frame start) when win_sel_i = 0, and ±19 T (offsets 569 to 607) when win_sel_i = 1. While locked, a sync inside the window gives a frame start with ins_o = 0 and restarts the offset count from that sync.
- R5: While locked, a sync outside the window gives no frame_o and does not move the frame timing.
- R6: While locked, if no sync has been accepted by offset 588 + window, that enabled cycle produces an inserted start: frame_o pulses and ins_o goes to 1 and stays 1 until the next frame start. The timing is placed at the nominal offset 588, so the next sync is expected 588 T after that nominal point.
- R7: hold_sel_i sets how many inserted frames may follow one another before lock drops: 00 = 2, 01 = 4, 10 = 8, 11 = 12. lock_o falls together with the strobe of the last allowed inserted frame. An accepted sync resets the count of inserted frames to zero.
- R8: While unlocked, no inserted starts are produced: with no sync, frame_o stays 0.
- R9: rate_o is 001 for speed_sel_i = 00 (normal), 010 for 01 (double) and 100 for 10 (quadruple). Code 11 gives 100, the same as 10.
- R10: sync_i is ignored while bit_en_i is low, and the offset count advances only on cycles where bit_en_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One channel-bit period elapsed |
| sync_i | input | 1 | Sync pattern detected, qualified by bit_en_i |
| win_sel_i | input | 1 | Window select: 0 = ±10 T, 1 = ±19 T |
| hold_sel_i | input | 2 | Code for the number of missing-sync frames tolerated |
| speed_sel_i | input | 2 | Play-speed code |
| lock_o | output | 1 | Frame timing is locked |
| frame_o | output | 1 | Frame start strobe, real or inserted |
| ins_o | output | 1 | Current frame start was inserted |
| rate_o | output | 3 | One-hot channel-bit rate request: x1, x2, x4 |

## Verification
The assertions take for granted that bit_en_i and sync_i are known from reset onward. Under that assumption, lock_o can change only in a cycle where frame_o pulses, and inserted starts appear only while the block was locked. The stimulus drives every input at the falling clock edge and holds bit_en_i low through reset. It changes win_sel_i and hold_sel_i only between frames, so every window limit and hold count applies to a whole frame.

// File: rtl/cd_sync_lock_pkg.sv
package cd_sync_lock_pkg;
  localparam int HOLD_W = 4;

  typedef enum logic [1:0] {
    SPD_X1  = 2'b00,
    SPD_X2  = 2'b01,
    SPD_X4  = 2'b10,
    SPD_X4B = 2'b11
  } speed_e;

  function automatic logic [HOLD_W-1:0] hold_frames(input logic [1:0] code);
    case (code)
      2'b00:   return HOLD_W'(2);
      2'b01:   return HOLD_W'(4);
      2'b10:   return HOLD_W'(8);
      default: return HOLD_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/cd_sync_phase.sv
// T offset since last frame start; saturates so stale references never match
module cd_sync_phase #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= CNT_MAX;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cd_sync_win.sv
module cd_sync_win #(
  parameter int FRAME_T = 588,
  parameter int WIN_N   = 10,
  parameter int WIN_W   = 19,
  parameter int CNT_W   = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             win_sel_i,
  output logic             in_win_o,
  output logic             close_o,
  output logic [CNT_W-1:0] realign_o
);
  localparam logic [CNT_W-1:0] LO_N = CNT_W'(FRAME_T - WIN_N);
  localparam logic [CNT_W-1:0] HI_N = CNT_W'(FRAME_T + WIN_N);
  localparam logic [CNT_W-1:0] LO_W = CNT_W'(FRAME_T - WIN_W);
  localparam logic [CNT_W-1:0] HI_W = CNT_W'(FRAME_T + WIN_W);
  // offset the counter holds right after an inserted start, nominal start at FRAME_T
  localparam logic [CNT_W-1:0] RE_N = CNT_W'(WIN_N + 1);
  localparam logic [CNT_W-1:0] RE_W = CNT_W'(WIN_W + 1);

  logic [CNT_W-1:0] lo, hi;

  always_comb begin
    lo        = win_sel_i ? LO_W : LO_N;
    hi        = win_sel_i ? HI_W : HI_N;
    realign_o = win_sel_i ? RE_W : RE_N;
    in_win_o  = (cnt_i >= lo) && (cnt_i <= hi);
    close_o   = (cnt_i == hi);
  end
endmodule

// File: rtl/cd_sync_hold.sv
module cd_sync_hold
  import cd_sync_lock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] hold_sel_i,
  input  logic       miss_i,
  input  logic       clear_i,
  output logic       drop_o
);
  logic [HOLD_W-1:0] miss_q;
  logic [HOLD_W:0]   miss_nx;
  logic [HOLD_W-1:0] limit;

  always_comb begin
    limit   = hold_frames(hold_sel_i);
    miss_nx = {1'b0, miss_q} + 1'b1;
    drop_o  = miss_i && (miss_nx >= {1'b0, limit});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               miss_q <= '0;
    else if (clear_i || drop_o) miss_q <= '0;
    else if (miss_i)           miss_q <= miss_nx[HOLD_W-1:0];
  end
endmodule

// File: rtl/cd_sync_rate.sv
module cd_sync_rate
  import cd_sync_lock_pkg::*;
(
  input  logic [1:0] speed_sel_i,
  output logic [2:0] rate_o
);
  speed_e spd;

  always_comb begin
    spd = speed_e'(speed_sel_i);
    case (spd)
      SPD_X1:  rate_o = 3'b001;
      SPD_X2:  rate_o = 3'b010;
      default: rate_o = 3'b100;
    endcase
  end
endmodule

// File: rtl/cd_sync_lock.sv
module cd_sync_lock #(
  parameter int FRAME_T = 588,
  parameter int WIN_N   = 10,
  parameter int WIN_W   = 19
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       sync_i,
  input  logic       win_sel_i,
  input  logic [1:0] hold_sel_i,
  input  logic [1:0] speed_sel_i,
  output logic       lock_o,
  output logic       frame_o,
  output logic       ins_o,
  output logic [2:0] rate_o
);
  localparam int CNT_W = $clog2(FRAME_T + WIN_W + 2);

  logic [CNT_W-1:0] cnt, realign, load_val;
  logic in_win, close, drop;
  logic hit, acc_lock, acc_unl, insert, start, gain;
  logic lock_q, ref_q, frame_q, ins_q;

  cd_sync_phase #(.CNT_W(CNT_W)) i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (bit_en_i),
    .load_i     (start),
    .load_val_i (load_val),
    .cnt_o      (cnt)
  );

  cd_sync_win #(
    .FRAME_T (FRAME_T),
    .WIN_N   (WIN_N),
    .WIN_W   (WIN_W),
    .CNT_W   (CNT_W)
  ) i_win (
    .cnt_i     (cnt),
    .win_sel_i (win_sel_i),
    .in_win_o  (in_win),
    .close_o   (close),
    .realign_o (realign)
  );

  cd_sync_hold i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_sel_i (hold_sel_i),
    .miss_i     (insert),
    .clear_i    (acc_lock || acc_unl),
    .drop_o     (drop)
  );

  cd_sync_rate i_rate (
    .speed_sel_i (speed_sel_i),
    .rate_o      (rate_o)
  );

  always_comb begin
    hit      = bit_en_i && sync_i;
    acc_lock = lock_q && hit && in_win;
    acc_unl  = !lock_q && hit;
    insert   = lock_q && bit_en_i && close && !acc_lock;
    start    = acc_lock || acc_unl || insert;
    gain     = acc_unl && ref_q && in_win;
    load_val = insert ? realign : CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      ref_q   <= 1'b0;
      frame_q <= 1'b0;
      ins_q   <= 1'b0;
    end else begin
      frame_q <= start;
      if (start) ins_q <= insert;
      if (gain)               lock_q <= 1'b1;
      else if (insert && drop) lock_q <= 1'b0;
      if (acc_unl)            ref_q <= 1'b1;
      else if (insert && drop) ref_q <= 1'b0;
    end
  end

  assign lock_o  = lock_q;
  assign frame_o = frame_q;
  assign ins_o   = ins_q;
endmodule

// File: rtl/cd_sync_lock_chk.sv
module cd_sync_lock_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       sync_i,
  input logic [1:0] speed_sel_i,
  input logic       lock_o,
  input logic       frame_o,
  input logic       ins_o,
  input logic [2:0] rate_o
);
  // R3
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> frame_o && !ins_o);

  // R7
  lock_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> frame_o && ins_o);

  // R6
  ins_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ins_o) |-> frame_o && $past(lock_o));

  // R8
  ins_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && !$past(lock_o)) |-> !ins_o);

  // R10
  frame_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> $past(bit_en_i));

  // R10
  lock_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_en_i) |-> $stable(lock_o));

  // R9
  rate_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rate_o) == 1);

  // R9
  rate_quad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_sel_i[1] |-> rate_o == 3'b100);
endmodule

bind cd_sync_lock cd_sync_lock_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_en_i    (bit_en_i),
  .sync_i      (sync_i),
  .speed_sel_i (speed_sel_i),
  .lock_o      (lock_o),
  .frame_o     (frame_o),
  .ins_o       (ins_o),
  .rate_o      (rate_o)
);

// File: tb/test_cd_sync_lock.sv
`timescale 1ns/1ps
module test_cd_sync_lock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       sync_i = 1'b0;
  logic       win_sel_i = 1'b0;
  logic [1:0] hold_sel_i = 2'b00;
  logic [1:0] speed_sel_i = 2'b00;
  logic       lock_o, frame_o, ins_o;
  logic [2:0] rate_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int strobes;

  always #5 clk_i = ~clk_i;

  cd_sync_lock i_cd_sync_lock (.*);

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one enabled channel-bit period; outputs sampled just after the edge
  task automatic tick(input logic s);
    @(negedge clk_i);
    bit_en_i = 1'b1;
    sync_i   = s;
    @(posedge clk_i);
    #1;
    if (frame_o) strobes++;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic acquire();
    tick(1'b1);
    gap(587);
    tick(1'b1);
  endtask

  task automatic t_reset();
    #1;
    check("R1 lock in reset", lock_o, 0);
    check("R1 frame in reset", frame_o, 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    check("R1 lock after reset", lock_o, 0);
    check("R1 ins after reset", ins_o, 0);
    check("R1 frame after reset", frame_o, 0);
  endtask

  task automatic t_acquire_spacing();
    tick(1'b1);
    check("R2 first sync strobe", frame_o, 1);
    check("R2 first sync no lock", lock_o, 0);
    gap(499);
    tick(1'b1);
    check("R3 bad spacing strobe", frame_o, 1);
    check("R3 bad spacing no lock", lock_o, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      bit_en_i = 1'b0;
      sync_i   = 1'b1;
      @(posedge clk_i);
      #1;
      check("R10 sync without enable", frame_o, 0);
    end
    gap(587);
    tick(1'b1);
    check("R3 lock on 588 spacing", lock_o, 1);
    check("R3 strobe on lock", frame_o, 1);
    check("R2 real start ins", ins_o, 0);
  endtask

  task automatic t_narrow();
    win_sel_i = 1'b0;
    gap(577);
    tick(1'b1);
    check("R4 narrow low edge", frame_o, 1);
    gap(597);
    tick(1'b1);
    check("R4 narrow high edge", frame_o, 1);
    check("R4 narrow real ins", ins_o, 0);
    gap(576);
    tick(1'b1);
    check("R5 outside narrow ignored", frame_o, 0);
    check("R5 lock kept", lock_o, 1);
    gap(20);
    tick(1'b0);
    check("R5 R6 insert at window close", frame_o, 1);
    check("R6 insert flag", ins_o, 1);
    tick(1'b0);
    check("R6 insert flag held", ins_o, 1);
    check("R6 strobe one cycle", frame_o, 0);
    gap(576);
    tick(1'b1);
    check("R6 nominal realign accept", frame_o, 1);
    check("R6 flag cleared by real start", ins_o, 0);
  endtask

  task automatic t_wide();
    win_sel_i = 1'b1;
    gap(568);
    tick(1'b1);
    check("R4 wide low edge", frame_o, 1);
    gap(606);
    tick(1'b1);
    check("R4 wide high edge", frame_o, 1);
    gap(567);
    tick(1'b1);
    check("R5 outside wide ignored", frame_o, 0);
    gap(38);
    tick(1'b0);
    check("R6 wide insert", ins_o, 1);
    check("R6 wide insert strobe", frame_o, 1);
    win_sel_i = 1'b0;
    gap(568);
    tick(1'b1);
    check("R6 wide nominal realign", frame_o, 1);
    check("R7 lock after one miss", lock_o, 1);
  endtask

  task automatic t_hold(input logic [1:0] code, input int n);
    hold_sel_i = code;
    for (int k = 1; k <= n; k++) begin
      gap(k == 1 ? 597 : 587);
      tick(1'b0);
      check("R7 hold insert strobe", frame_o, 1);
      check("R7 hold insert flag", ins_o, 1);
      check("R7 hold lock state", lock_o, (k < n) ? 1 : 0);
    end
    strobes = 0;
    gap(1300);
    check("R8 no strobes unlocked", strobes, 0);
    acquire();
    check("R7 reacquire", lock_o, 1);
  endtask

  task automatic t_miss_clear();
    hold_sel_i = 2'b00;
    gap(597);
    tick(1'b0);
    check("R7 first miss", lock_o, 1);
    gap(576);
    tick(1'b1);
    check("R7 accept after miss", ins_o, 0);
    gap(597);
    tick(1'b0);
    check("R7 count cleared by sync", lock_o, 1);
    gap(587);
    tick(1'b0);
    check("R7 drop on second miss", lock_o, 0);
    acquire();
  endtask

  task automatic t_speed();
    int exp_rate [4] = '{1, 2, 4, 4};
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      speed_sel_i = 2'(c);
      #1;
      check("R9 rate decode", rate_o, exp_rate[c]);
    end
  endtask

  initial begin
    int exp_hold [4] = '{2, 4, 8, 12};
    strobes = 0;
    t_reset();
    t_acquire_spacing();
    t_narrow();
    t_wide();
    for (int c = 0; c < 4; c++) t_hold(2'(c), exp_hold[c]);
    t_miss_clear();
    t_speed();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule